// File: doc/BRIEF.md
# Ethernet transmit frame formatter

This block sits in a 10/100 transmit path between a byte-stream frame source and the MAC that serialises frames onto the medium. The source hands over a frame that starts with the destination address and continues with an optional source field, the type/length field and the payload. On its way through, the block can put the programmed station address into the source field, either by replacing the six bytes already present or by inserting six new bytes after the destination. It can also extend short frames with zero bytes and add the 32-bit frame check sequence at the end.

Both sides are valid/ready byte streams with first and last markers. The block keeps no frame storage. In pass-through phases the input is accepted only in a cycle where the output is taken. During inserted, padding and check bytes the input is held off. Four static option inputs pick the operations. They are captured with the first byte of each frame, so a change only takes effect from the next frame.

Top module: `eth_tx_shaper`

## Requirements
- R1: With all options off, every input byte leaves unchanged and in order. The input side is ready only in a cycle where the output side is ready, because the block holds no frame storage.
- R2: With address insertion on and overwrite on, output bytes 6 to 11 (counting from 0) are taken from the station address, most significant byte (`stationAddr[47:40]`) first. All other bytes pass unchanged.
- R3: With address insertion on and overwrite off, six station-address bytes (most significant first) are emitted after input byte 5. During those six bytes the input is stalled, and the rest of the input follows them.
- R4: With address insertion off, the overwrite option has no effect on the output.
- R5: With padding on, a frame whose body (everything before the check sequence) is shorter than 60 bytes is extended with 0x00 bytes up to exactly 60 bytes.
- R6: With check insertion on, four bytes follow the body and any padding. They hold the bitwise inverse of the reflected CRC-32 (polynomial 0xEDB88320, start value 0xFFFFFFFF) over all preceding output bytes, least significant byte first.
- R7: A body of 60 bytes or more is never padded, and with padding off a short frame stays short.
- R8: The option inputs are sampled with the first byte of a frame. Changing them while the frame is in progress does not alter that frame.
- R9: `outFirst` marks the first output byte of each frame and `outLast` marks exactly the last one: the last check byte when check insertion is on, otherwise the last pad or body byte.
- R10: While `outValid` is high and `outReady` low, `outValid`, `outData` and `outLast` hold in the next cycle, given that the source also holds its byte.
- R11: After reset, no output byte is offered until an input frame arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| optInsSa | input | 1 | Put the station address into the source field |
| optOvwSa | input | 1 | Replace the existing source bytes instead of inserting (only with optInsSa) |
| optPad | input | 1 | Pad short frames to 60 bytes |
| optFcs | input | 1 | Append the 4-byte check sequence |
| stationAddr | input | 48 | Station address, bits 47:40 sent first |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inFirst | input | 1 | Input byte is the first of a frame |
| inLast | input | 1 | Input byte is the last of a frame |
| inReady | output | 1 | Input byte accepted this cycle when valid |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outFirst | output | 1 | Output byte is the first of a frame |
| outLast | output | 1 | Output byte is the last of a frame |
| outReady | input | 1 | Sink takes the output byte |

## Verification
Several properties are checked on every cycle. An accepted input byte always coincides with an accepted output byte. A stalled output byte holds steady. A byte offered outside a frame carries the first marker. Every completed frame that had padding on meets the minimum length. Every frame with the check sequence leaves the CRC register at the fixed residue after its last byte. Only the bench scenarios can show that the right bytes appear in the right places: the address window, the six inserted bytes, zero padding, the boundary at exactly 60 bytes, and that a mid-frame option change has no effect.

// File: rtl/eth_tx_shaper_pkg.sv
package eth_tx_shaper_pkg;

  typedef enum logic [1:0] {
    PH_PASS,
    PH_ADDR,
    PH_PAD,
    PH_FCS
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       fire;     // output byte taken this cycle
    logic       first;    // byte is the first of a frame
    logic       useAddr;  // drive a station-address byte
    logic [2:0] addrIdx;  // which address byte, 0 = most significant
    logic       usePad;   // drive a zero byte
    logic       useFcs;   // drive a check byte
    logic [1:0] fcsIdx;   // which check byte, 0 = least significant
  } strobe_t;

  function automatic logic [31:0] crcStep(logic [31:0] crc, logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_tx_shaper_ctrl.sv
module eth_tx_shaper_ctrl
  import eth_tx_shaper_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_BODY   = 60,
  parameter int CNT_W      = 11
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    optInsSa,
  input  logic    optOvwSa,
  input  logic    optPad,
  input  logic    optFcs,
  input  logic    inValid,
  input  logic    inFirst,
  input  logic    inLast,
  output logic    inReady,
  output logic    outValid,
  output logic    outFirst,
  output logic    outLast,
  input  logic    outReady,
  output strobe_t strobe
);

  localparam int AIDX_W = $clog2(ADDR_BYTES);
  localparam logic [CNT_W-1:0] ADDR_LO   = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] ADDR_HI   = CNT_W'(2 * ADDR_BYTES);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(MIN_BODY - 1);
  localparam logic [CNT_W-1:0] INS_AFTER = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] INS_LAST  = CNT_W'(2 * ADDR_BYTES - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;       // body bytes emitted so far
  logic [1:0]       fcsCnt;
  logic             insL, ovwL, padL, fcsL;

  logic             startByte;
  logic             insE, ovwE, padE, fcsE;
  logic             ovwOn, insOn, padNeed, fire;
  logic [CNT_W-1:0] addrOff;

  assign startByte = (phase == PH_PASS) && inFirst;
  assign insE      = startByte ? optInsSa : insL;
  assign ovwE      = startByte ? optOvwSa : ovwL;
  assign padE      = startByte ? optPad   : padL;
  assign fcsE      = startByte ? optFcs   : fcsL;
  assign ovwOn     = insE && ovwE;
  assign insOn     = insE && !ovwE;
  assign padNeed   = padE && ((int'(cnt) + 1) < MIN_BODY);
  assign addrOff   = cnt - ADDR_LO;

  always_comb begin
    inReady  = 1'b0;
    outValid = 1'b0;
    outFirst = 1'b0;
    outLast  = 1'b0;
    strobe   = '0;
    strobe.addrIdx = 3'(addrOff[AIDX_W-1:0]);
    strobe.fcsIdx  = fcsCnt;
    unique case (phase)
      PH_PASS: begin
        outValid       = inValid;
        inReady        = outReady;
        outFirst       = inFirst;
        outLast        = inLast && !padNeed && !fcsE;
        strobe.useAddr = ovwOn && (cnt >= ADDR_LO) && (cnt < ADDR_HI);
      end
      PH_ADDR: begin
        outValid       = 1'b1;
        strobe.useAddr = 1'b1;
      end
      PH_PAD: begin
        outValid      = 1'b1;
        strobe.usePad = 1'b1;
        outLast       = !fcsL && (cnt == PAD_LAST);
      end
      default: begin
        outValid      = 1'b1;
        strobe.useFcs = 1'b1;
        outLast       = (fcsCnt == 2'd3);
      end
    endcase
    fire         = outValid && outReady;
    strobe.fire  = fire;
    strobe.first = outFirst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_PASS;
      cnt    <= '0;
      fcsCnt <= '0;
      insL   <= 1'b0;
      ovwL   <= 1'b0;
      padL   <= 1'b0;
      fcsL   <= 1'b0;
    end else if (fire) begin
      unique case (phase)
        PH_PASS: begin
          if (startByte) begin
            insL <= optInsSa;
            ovwL <= optOvwSa;
            padL <= optPad;
            fcsL <= optFcs;
          end
          cnt <= cnt + 1'b1;
          if (inLast) begin
            fcsCnt <= '0;
            if (padNeed)   phase <= PH_PAD;
            else if (fcsE) phase <= PH_FCS;
            else           cnt   <= '0;
          end else if (insOn && cnt == INS_AFTER) begin
            phase <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          cnt <= cnt + 1'b1;
          if (cnt == INS_LAST) phase <= PH_PASS;
        end
        PH_PAD: begin
          cnt <= cnt + 1'b1;
          if (cnt == PAD_LAST) begin
            if (fcsL) phase <= PH_FCS;
            else begin
              phase <= PH_PASS;
              cnt   <= '0;
            end
          end
        end
        default: begin
          fcsCnt <= fcsCnt + 1'b1;
          if (fcsCnt == 2'd3) begin
            phase <= PH_PASS;
            cnt   <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/eth_tx_shaper_dp.sv
module eth_tx_shaper_dp
  import eth_tx_shaper_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [7:0]              inData,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  output logic [7:0]              outData
);

  logic [7:0]  addrByte [8];
  logic [31:0] crc;

  // address bytes in transmit order, most significant first
  for (genvar g = 0; g < 8; g++) begin : g_addr
    if (g < ADDR_BYTES) begin : g_used
      assign addrByte[g] = stationAddr[8*(ADDR_BYTES-1-g) +: 8];
    end else begin : g_spare
      assign addrByte[g] = 8'h00;
    end
  end

  always_comb begin
    if (strobe.useFcs)       outData = ~crc[8*strobe.fcsIdx +: 8];
    else if (strobe.usePad)  outData = 8'h00;
    else if (strobe.useAddr) outData = addrByte[strobe.addrIdx];
    else                     outData = inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crc <= '1;
    end else if (strobe.fire && !strobe.useFcs) begin
      crc <= crcStep(strobe.first ? 32'hFFFFFFFF : crc, outData);
    end
  end

endmodule

// File: rtl/eth_tx_shaper.sv
module eth_tx_shaper
  import eth_tx_shaper_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_BODY   = 60,
  parameter int MAX_FRAME  = 1522,
  localparam int CNT_W     = $clog2(MAX_FRAME + ADDR_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        optInsSa,
  input  logic        optOvwSa,
  input  logic        optPad,
  input  logic        optFcs,
  input  logic [47:0] stationAddr,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inFirst,
  input  logic        inLast,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        outFirst,
  output logic        outLast,
  input  logic        outReady
);

  strobe_t strobe;

  eth_tx_shaper_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .MIN_BODY(MIN_BODY), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .optInsSa(optInsSa), .optOvwSa(optOvwSa), .optPad(optPad), .optFcs(optFcs),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outFirst(outFirst), .outLast(outLast),
    .outReady(outReady), .strobe(strobe)
  );

  eth_tx_shaper_dp #(
    .ADDR_BYTES(ADDR_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .stationAddr(stationAddr[8*ADDR_BYTES-1:0]), .outData(outData)
  );

endmodule

// File: rtl/eth_tx_shaper_chk.sv
module eth_tx_shaper_chk
  import eth_tx_shaper_pkg::*;
#(
  parameter int MIN_BODY = 60
) (
  input logic       clk,
  input logic       rstN,
  input logic       optPad,
  input logic       optFcs,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outFirst,
  input logic       outLast,
  input logic       outReady
);

  logic        inFrame, padL, fcsL;
  logic [15:0] lenCnt;
  logic [31:0] crcRun;
  logic        oFire, padNow, fcsNow;
  logic [15:0] curLen;
  logic [31:0] crcNow;

  assign oFire  = outValid && outReady;
  assign padNow = outFirst ? optPad : padL;
  assign fcsNow = outFirst ? optFcs : fcsL;
  assign curLen = (outFirst ? 16'd0 : lenCnt) + 16'd1;
  assign crcNow = crcStep(outFirst ? 32'hFFFFFFFF : crcRun, outData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      padL    <= 1'b0;
      fcsL    <= 1'b0;
      lenCnt  <= '0;
      crcRun  <= '1;
    end else if (oFire) begin
      inFrame <= !outLast;
      padL    <= padNow;
      fcsL    <= fcsNow;
      lenCnt  <= outLast ? 16'd0 : curLen;
      crcRun  <= crcNow;
    end
  end

  // R1: input taken only together with an output byte
  a_r1_no_buffer: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (outValid && outReady));

  // R10: stalled output holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R5: padded frames meet the minimum length
  a_r5_min_len: assert property (@(posedge clk) disable iff (!rstN)
    (oFire && outLast && padNow) |-> (curLen >= 16'(fcsNow ? MIN_BODY + 4 : MIN_BODY)));

  // R6: CRC over the whole frame including check bytes leaves the residue
  a_r6_residue: assert property (@(posedge clk) disable iff (!rstN)
    (oFire && outLast && fcsNow) |-> (crcNow == 32'hDEBB20E3));

  // R9: a byte offered outside a frame starts one
  a_r9_first_mark: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !inFrame) |-> outFirst);

endmodule

bind eth_tx_shaper eth_tx_shaper_chk #(.MIN_BODY(MIN_BODY)) u_chk (
  .clk(clk), .rstN(rstN), .optPad(optPad), .optFcs(optFcs),
  .inValid(inValid), .inReady(inReady), .outValid(outValid),
  .outData(outData), .outFirst(outFirst), .outLast(outLast),
  .outReady(outReady)
);

// File: tb/test_eth_tx_shaper.sv
module test_eth_tx_shaper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        optInsSa = 1'b0, optOvwSa = 1'b0, optPad = 1'b0, optFcs = 1'b0;
  logic [47:0] stationAddr = 48'h02_1A_2B_3C_4D_5E;
  logic        inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady, outValid, outFirst, outLast;
  logic [7:0]  outData;
  logic        outReady = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;

  eth_tx_shaper i_eth_tx_shaper (
    .clk(clk), .rstN(rstN),
    .optInsSa(optInsSa), .optOvwSa(optOvwSa), .optPad(optPad), .optFcs(optFcs),
    .stationAddr(stationAddr),
    .inValid(inValid), .inData(inData), .inFirst(inFirst), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outFirst(outFirst), .outLast(outLast), .outReady(outReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input logic [7:0] q[$]);
    logic [31:0] r = 32'hFFFFFFFF;
    foreach (q[i]) begin
      for (int b = 0; b < 8; b++) begin
        if (r[0] ^ q[i][b]) r = (r >> 1) ^ 32'hEDB88320;
        else                r = r >> 1;
      end
    end
    return ~r;
  endfunction

  // opts: [3] insert, [2] overwrite, [1] pad, [0] check sequence
  task automatic runFrame(input int len, input logic [7:0] seed, input logic [3:0] opts,
                          input bit stall, input bit flipMid, input string req);
    logic [7:0] src[$];
    logic [7:0] exp[$];
    logic [31:0] c;
    int idx = 0;
    int pos = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit held = 1'b0;
    logic [7:0] heldData = 8'h00;
    for (int i = 0; i < len; i++) src.push_back(seed + 8'(i * 7));
    for (int i = 0; i < len; i++) begin
      if (opts[3] && opts[2] && i >= 6 && i < 12) exp.push_back(stationAddr[8*(11-i) +: 8]);
      else exp.push_back(src[i]);
      if (opts[3] && !opts[2] && i == 5)
        for (int a = 0; a < 6; a++) exp.push_back(stationAddr[8*(5-a) +: 8]);
    end
    if (opts[1]) while (exp.size() < 60) exp.push_back(8'h00);
    if (opts[0]) begin
      c = refCrc(exp);
      for (int k = 0; k < 4; k++) exp.push_back(c[8*k +: 8]);
    end
    {optInsSa, optOvwSa, optPad, optFcs} = opts;
    while (!done) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      outReady = stall ? lfsr[0] : 1'b1;
      if (flipMid && idx == 8) {optInsSa, optOvwSa, optPad, optFcs} = ~opts;
      if (idx < len) begin
        inValid = 1'b1;
        inData  = src[idx];
        inFirst = (idx == 0);
        inLast  = (idx == len - 1);
      end else begin
        inValid = 1'b0;
        inFirst = 1'b0;
        inLast  = 1'b0;
      end
      #8;
      if (held) check(outValid && outData == heldData, "R10 hold", outData, heldData);
      held = outValid && !outReady;
      heldData = outData;
      if (inValid && inReady) idx++;
      if (outValid && outReady) begin
        if (exp.size() == 0) begin
          check(1'b0, req, outData, 0);
          done = 1'b1;
        end else begin
          check(outData == exp[0], req, outData, exp[0]);
          void'(exp.pop_front());
          check(outFirst == (pos == 0), "R9 first", outFirst, pos == 0);
          check(outLast == (exp.size() == 0), "R9 last", outLast, exp.size() == 0);
          pos++;
          if (outLast || exp.size() == 0) done = 1'b1;
        end
      end
      cyc++;
      if (cyc > 10000) begin
        check(1'b0, "frame timeout", pos, exp.size());
        done = 1'b1;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inFirst = 1'b0;
    inLast  = 1'b0;
    check(exp.size() == 0, req, exp.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #8;
    check(outValid == 1'b0, "R11 reset", outValid, 0);
    check(inReady == outReady, "R1 ready", inReady, outReady);
    runFrame(20, 8'h10, 4'b0000, 1'b0, 1'b0, "R1 passthrough");
    runFrame(24, 8'h33, 4'b0000, 1'b1, 1'b0, "R1 stalled");
    runFrame(20, 8'h20, 4'b1100, 1'b1, 1'b0, "R2 overwrite");
    runFrame(14, 8'h30, 4'b1000, 1'b0, 1'b0, "R3 insert");
    runFrame(30, 8'h31, 4'b1000, 1'b1, 1'b0, "R3 insert stalled");
    runFrame(20, 8'h40, 4'b0100, 1'b0, 1'b0, "R4 overwrite alone");
    runFrame(20, 8'h50, 4'b0010, 1'b1, 1'b0, "R5 pad");
    runFrame(59, 8'h51, 4'b0010, 1'b0, 1'b0, "R5 pad one byte");
    runFrame(64, 8'h60, 4'b0001, 1'b1, 1'b0, "R6 fcs");
    runFrame(20, 8'h61, 4'b1111, 1'b1, 1'b0, "R6 all options");
    runFrame(40, 8'h62, 4'b1011, 1'b0, 1'b0, "R6 insert pad fcs");
    runFrame(60, 8'h70, 4'b0011, 1'b0, 1'b0, "R7 exact minimum");
    runFrame(70, 8'h71, 4'b0011, 1'b1, 1'b0, "R7 long");
    runFrame(16, 8'h72, 4'b0001, 1'b0, 1'b0, "R7 pad off");
    runFrame(20, 8'h80, 4'b0000, 1'b1, 1'b1, "R8 change mid frame");
    runFrame(20, 8'h81, 4'b1111, 1'b0, 1'b1, "R8 change back");
    runFrame(1518, 8'h90, 4'b1101, 1'b0, 1'b0, "R6 max frame");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule